// File: doc/BRIEF.md
# Select-Gated SPI Slave Port

This block is the slave side of an SPI link. The external master supplies the serial clock on `sck`, and the shift engine is clocked by `sck` and nothing else. The port never makes a clock of its own. Because of this, a byte can be shifted in while the system clock `clk` is stopped. A finished byte then raises a wake request on a path that needs no `clk` edge. Once `clk` runs again, the completion event crosses into the `clk` domain through a two-flop toggle synchronizer. The received word is then copied into a parallel buffer and a sticky completion flag is set.

A 4-bit mode input picks the select behaviour. Code 4'h4 honours the active-low select. While select is high the engine is held cleared, and `sdo_oe` drops at once, even partway through a byte. Code 4'h5 ignores select, so the engine can only be cleared through the enable input. Any other code, or `enable` low, holds the engine cleared and leaves `sdo` undriven. The transmit word comes from a buffer loaded in the `clk` domain. A load made while a transfer is under way is discarded and sets a collision flag.

Top module: `spi_slave_port`

## Requirements
- R1: `sdi` is sampled on each rising `sck` edge, most significant bit first. After eight rising edges the assembled byte appears on `rx_data`.
- R2: Once a byte completes and `clk` runs, `byte_done` goes to 1 within four `clk` cycles. It stays 1 until a cycle with `flag_clr` high, and a new completion in that same cycle wins.
- R3: `sdo` carries the transmit buffer MSB first. Bit 7 is valid before the first rising edge, and each later bit is valid before the following rising edge, because `sdo` changes on falling `sck` edges.
- R4: In mode 4'h4 with `enable` high and `tx_disable` low, `sdo_oe` is 1 while `ss_n` is low.
- R5: In mode 4'h4, `ss_n` high forces `sdo_oe` to 0 with no clock edge. It also clears the bit count, so a partial byte is discarded and the next selected byte is received aligned.
- R6: `enable` low forces `sdo_oe` to 0 and clears the bit count, which also aborts a partial byte in mode 4'h5.
- R7: `wake` is 1 when `irq_en` is 1 and either a completed byte has not yet reached the `clk` domain or `byte_done` is 1. It rises with `clk` stopped.
- R8: `tx_disable` high keeps `sdo_oe` at 0 while reception works as usual.
- R9: In mode 4'h5, `ss_n` has no effect. `sdo_oe` is 1 and bytes are received with `ss_n` high.
- R10: A `tx_wr` pulse while a transfer is under way leaves the transmit buffer unchanged and sets `wcol`, which stays set until `wcol_clr`. A write while idle replaces the buffer.
- R11: Any mode code other than 4'h4 or 4'h5 holds the engine cleared. No byte completes and `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, may be stopped |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| ss_n | input | 1 | Active-low select |
| enable | input | 1 | Port enable |
| mode | input | 4 | 4'h4 select honoured, 4'h5 select ignored |
| tx_disable | input | 1 | Keep sdo undriven (receive-only) |
| irq_en | input | 1 | Allow completion to request wake |
| tx_wr | input | 1 | Load transmit buffer |
| tx_data | input | 8 | Transmit buffer data |
| flag_clr | input | 1 | Clear byte_done |
| wcol_clr | input | 1 | Clear wcol |
| rx_data | output | 8 | Last received byte |
| byte_done | output | 1 | Sticky byte-complete flag |
| wcol | output | 1 | Write-collision flag |
| wake | output | 1 | Wake request |

## Verification
The assertions sample on `clk`. They assume that `sck` edges are far enough apart for the two-flop synchronizers to see each completion toggle and each change of the busy level. They also assume that buffer writes made while idle settle before the first falling `sck` edge of a transfer. The stimulus runs `sck` at a 40 ns period, ten `clk` periods. Every write and select change is followed by several idle `clk` cycles, except where a collision is provoked on purpose. During the stopped-clock run only port levels are compared, and no clocked check is taken until `clk` has restarted.

// File: rtl/spis_pkg.sv
`timescale 1ns/1ps
package spis_pkg;
   localparam logic [3:0] SPIS_MODE_SEL  = 4'h4;
   localparam logic [3:0] SPIS_MODE_FREE = 4'h5;

   typedef enum logic [1:0] {
      ENG_OFF  = 2'd0,
      ENG_SEL  = 2'd1,
      ENG_FREE = 2'd2
   } spis_eng_e;

   function automatic spis_eng_e spis_decode(input logic en, input logic [3:0] m);
      if (!en)                 return ENG_OFF;
      if (m == SPIS_MODE_SEL)  return ENG_SEL;
      if (m == SPIS_MODE_FREE) return ENG_FREE;
      return ENG_OFF;
   endfunction
endpackage

// File: rtl/spis_bit_sync.sv
`timescale 1ns/1ps
module spis_bit_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spis_shift_engine.sv
`timescale 1ns/1ps
module spis_shift_engine #(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              sck,
   input  logic              rst_n,
   input  logic              eng_clr,
   input  logic              sdi,
   input  logic [DATA_W-1:0] tx_word,
   output logic              sdo_bit,
   output logic [DATA_W-1:0] rx_word,
   output logic              done_tgl,
   output logic              busy
);
   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] rx_sh, tx_sh;
   logic [DATA_W-1:0] rx_next, tx_load_next, tx_run_next;
   logic              head_word, head_run;

   if (MSB_FIRST) begin : g_msb
      assign rx_next      = {rx_sh[DATA_W-2:0], sdi};
      assign tx_load_next = {tx_word[DATA_W-2:0], 1'b0};
      assign tx_run_next  = {tx_sh[DATA_W-2:0], 1'b0};
      assign head_word    = tx_word[DATA_W-1];
      assign head_run     = tx_sh[DATA_W-1];
   end else begin : g_lsb
      assign rx_next      = {sdi, rx_sh[DATA_W-1:1]};
      assign tx_load_next = {1'b0, tx_word[DATA_W-1:1]};
      assign tx_run_next  = {1'b0, tx_sh[DATA_W-1:1]};
      assign head_word    = tx_word[0];
      assign head_run     = tx_sh[0];
   end

   // receive side: rising edge
   always_ff @(posedge sck or posedge eng_clr) begin
      if (eng_clr) begin
         cnt   <= '0;
         rx_sh <= '0;
      end else begin
         rx_sh <= rx_next;
         cnt   <= (cnt == LAST) ? '0 : cnt + ONE;
      end
   end

   // completed word and event toggle survive a select abort
   always_ff @(posedge sck or negedge rst_n) begin
      if (!rst_n) begin
         rx_word  <= '0;
         done_tgl <= 1'b0;
      end else if (cnt == LAST) begin
         rx_word  <= rx_next;
         done_tgl <= ~done_tgl;
      end
   end

   // transmit side: falling edge
   always_ff @(negedge sck or posedge eng_clr) begin
      if (eng_clr)          tx_sh <= '0;
      else if (cnt == ONE)  tx_sh <= tx_load_next;
      else                  tx_sh <= tx_run_next;
   end

   assign sdo_bit = (cnt == '0) ? head_word : head_run;
   assign busy    = (cnt != '0);
endmodule

// File: rtl/spis_sys_side.sv
`timescale 1ns/1ps
module spis_sys_side #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tgl_sync,
   input  logic              tgl_raw,
   input  logic              busy_sync,
   input  logic [DATA_W-1:0] rx_word,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              flag_clr,
   input  logic              wcol_clr,
   input  logic              irq_en,
   output logic [DATA_W-1:0] tx_buf,
   output logic [DATA_W-1:0] rx_data,
   output logic              byte_done,
   output logic              wcol,
   output logic              wake,
   output logic              byte_evt
);
   logic seen;

   assign byte_evt = tgl_sync ^ seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen      <= 1'b0;
         rx_data   <= '0;
         byte_done <= 1'b0;
      end else begin
         seen <= tgl_sync;
         if (byte_evt) begin
            rx_data   <= rx_word;
            byte_done <= 1'b1;
         end else if (flag_clr) begin
            byte_done <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_buf <= '0;
         wcol   <= 1'b0;
      end else begin
         if (tx_wr && busy_sync)  wcol <= 1'b1;
         else if (wcol_clr)       wcol <= 1'b0;
         if (tx_wr && !busy_sync) tx_buf <= tx_data;
      end
   end

   // pending compare uses the raw toggle so it needs no clk edge
   assign wake = irq_en && (byte_done || (tgl_raw ^ seen));
endmodule

// File: rtl/spi_slave_port.sv
`timescale 1ns/1ps
module spi_slave_port #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_oe,
   input  logic              ss_n,
   input  logic              enable,
   input  logic [3:0]        mode,
   input  logic              tx_disable,
   input  logic              irq_en,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              flag_clr,
   input  logic              wcol_clr,
   output logic [DATA_W-1:0] rx_data,
   output logic              byte_done,
   output logic              wcol,
   output logic              wake
);
   import spis_pkg::*;

   if (DATA_W < 2) begin : g_bad_width
      $error("spi_slave_port: DATA_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spi_slave_port: SYNC_STAGES must be at least 2");
   end

   spis_eng_e         eng_mode;
   logic              eng_clr;
   logic              done_tgl, tgl_sync;
   logic              busy_raw, busy_s;
   logic              byte_evt;
   logic [DATA_W-1:0] rx_word, tx_buf;

   assign eng_mode = spis_decode(enable, mode);
   assign eng_clr  = !rst_n || (eng_mode == ENG_OFF) || ((eng_mode == ENG_SEL) && ss_n);
   assign sdo_oe   = rst_n && !tx_disable &&
                     ((eng_mode == ENG_FREE) || ((eng_mode == ENG_SEL) && !ss_n));

   spis_shift_engine #(.DATA_W(DATA_W), .MSB_FIRST(MSB_FIRST)) u_eng (
      .sck      (sck),
      .rst_n    (rst_n),
      .eng_clr  (eng_clr),
      .sdi      (sdi),
      .tx_word  (tx_buf),
      .sdo_bit  (sdo),
      .rx_word  (rx_word),
      .done_tgl (done_tgl),
      .busy     (busy_raw)
   );

   spis_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_done (
      .clk(clk), .rst_n(rst_n), .d(done_tgl), .q(tgl_sync)
   );

   spis_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_busy (
      .clk(clk), .rst_n(rst_n), .d(busy_raw), .q(busy_s)
   );

   spis_sys_side #(.DATA_W(DATA_W)) u_sys (
      .clk       (clk),
      .rst_n     (rst_n),
      .tgl_sync  (tgl_sync),
      .tgl_raw   (done_tgl),
      .busy_sync (busy_s),
      .rx_word   (rx_word),
      .tx_wr     (tx_wr),
      .tx_data   (tx_data),
      .flag_clr  (flag_clr),
      .wcol_clr  (wcol_clr),
      .irq_en    (irq_en),
      .tx_buf    (tx_buf),
      .rx_data   (rx_data),
      .byte_done (byte_done),
      .wcol      (wcol),
      .wake      (wake),
      .byte_evt  (byte_evt)
   );
endmodule

// File: rtl/spis_checker.sv
`timescale 1ns/1ps
module spis_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       enable,
   input logic [3:0] mode,
   input logic       ss_n,
   input logic       tx_disable,
   input logic       sdo_oe,
   input logic       tx_wr,
   input logic       busy_s,
   input logic       busy_raw,
   input logic       wcol,
   input logic       wcol_clr,
   input logic       byte_evt,
   input logic       byte_done,
   input logic       flag_clr,
   input logic       irq_en,
   input logic       wake
);
   a_r2_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
      byte_evt |=> byte_done);
   a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && !flag_clr) |=> byte_done);
   a_r5_deselect_floats: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 4'h4 && ss_n) |-> !sdo_oe);
   a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (!sdo_oe && !busy_raw));
   a_r7_wake_follows_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && byte_done) |-> wake);
   a_r8_rx_only: assert property (@(posedge clk) disable iff (!rst_n)
      tx_disable |-> !sdo_oe);
   a_r10_collision: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && busy_s) |=> wcol);
   a_r10_wcol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (wcol && !wcol_clr) |=> wcol);
   a_r11_bad_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 4'h4 && mode != 4'h5) |-> (!sdo_oe && !busy_raw));
endmodule

bind spi_slave_port spis_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .mode       (mode),
   .ss_n       (ss_n),
   .tx_disable (tx_disable),
   .sdo_oe     (sdo_oe),
   .tx_wr      (tx_wr),
   .busy_s     (busy_s),
   .busy_raw   (busy_raw),
   .wcol       (wcol),
   .wcol_clr   (wcol_clr),
   .byte_evt   (byte_evt),
   .byte_done  (byte_done),
   .flag_clr   (flag_clr),
   .irq_en     (irq_en),
   .wake       (wake)
);

// File: tb/spi_slave_port_bench.sv
`timescale 1ns/1ps
module spi_slave_port_bench;
   logic       clk = 1'b0;
   logic       clk_run = 1'b1;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0, sdi = 1'b0, ss_n = 1'b1;
   logic       enable = 1'b0, tx_disable = 1'b0, irq_en = 1'b0;
   logic [3:0] mode = 4'h4;
   logic       tx_wr = 1'b0, flag_clr = 1'b0, wcol_clr = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       sdo, sdo_oe, byte_done, wcol, wake;
   logic [7:0] rx_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = clk_run ? ~clk : clk;

   spi_slave_port u_spi_slave_port (
      .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
      .ss_n(ss_n), .enable(enable), .mode(mode), .tx_disable(tx_disable),
      .irq_en(irq_en), .tx_wr(tx_wr), .tx_data(tx_data), .flag_clr(flag_clr),
      .wcol_clr(wcol_clr), .rx_data(rx_data), .byte_done(byte_done),
      .wcol(wcol), .wake(wake)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // expected serial output sequence: MSB first of the buffered word
   function automatic logic [7:0] exp_miso(input logic [7:0] buf_word);
      return buf_word;
   endfunction

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic write_tx(input logic [7:0] v);
      @(negedge clk); tx_wr = 1'b1; tx_data = v;
      @(negedge clk); tx_wr = 1'b0;
   endtask

   task automatic pulse_flag_clr();
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
   endtask

   task automatic shift_bits(input logic [7:0] mosi, input int nbits, output logic [7:0] miso);
      miso = 8'h00;
      for (int i = 0; i < nbits; i++) begin
         sdi = mosi[7-i];
         #20;
         miso[7-i] = sdo;
         sck = 1'b1;
         #20;
         sck = 1'b0;
      end
   endtask

   task automatic full_byte(input string req, input logic [7:0] mosi, input logic [7:0] txw);
      logic [7:0] got;
      ss_n = 1'b0; #20;
      shift_bits(mosi, 8, got);
      #10; ss_n = 1'b1;
      idle(5);
      check({req, " rx_data"}, rx_data, mosi);
      check({req, " byte_done"}, byte_done, 1'b1);
      check({req, " miso"}, got, exp_miso(txw));
      pulse_flag_clr();
   endtask

   initial begin : watchdog
      #400000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] got, m, t;
      void'($urandom(32'h5a17));
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // reset state
      check("R2 reset byte_done", byte_done, 1'b0);
      check("R10 reset wcol", wcol, 1'b0);
      check("R1 reset rx_data", rx_data, 8'h00);
      check("R6 reset disabled oe", sdo_oe, 1'b0);

      enable = 1'b1; mode = 4'h4;
      idle(2);
      check("R5 idle deselected oe", sdo_oe, 1'b0);
      write_tx(8'hA5);
      idle(3);
      ss_n = 1'b0; #1;
      check("R4 selected oe", sdo_oe, 1'b1);
      #19;
      shift_bits(8'h3C, 8, got);
      #10; ss_n = 1'b1; #1;
      check("R5 deselect oe immediate", sdo_oe, 1'b0);
      idle(5);
      check("R1 rx byte", rx_data, 8'h3C);
      check("R3 miso byte", got, 8'hA5);
      check("R2 flag set", byte_done, 1'b1);
      idle(6);
      check("R2 flag sticky", byte_done, 1'b1);
      pulse_flag_clr();
      check("R2 flag cleared", byte_done, 1'b0);

      // abort mid-byte in select mode
      write_tx(8'h96);
      idle(3);
      ss_n = 1'b0; #20;
      shift_bits(8'hFF, 3, got);
      ss_n = 1'b1; #1;
      check("R5 abort floats sdo", sdo_oe, 1'b0);
      idle(5);
      check("R5 abort no completion", byte_done, 1'b0);
      full_byte("R5 realigned", 8'h81, 8'h96);

      // write collision
      write_tx(8'h5A);
      idle(3);
      ss_n = 1'b0; #20;
      shift_bits(8'h00, 4, got);
      idle(4);
      write_tx(8'hC3);
      check("R10 wcol set", wcol, 1'b1);
      idle(3);
      check("R10 wcol sticky", wcol, 1'b1);
      ss_n = 1'b1;
      idle(4);
      @(negedge clk); wcol_clr = 1'b1;
      @(negedge clk); wcol_clr = 1'b0;
      check("R10 wcol cleared", wcol, 1'b0);
      full_byte("R10 buffer kept", 8'h42, 8'h5A);
      write_tx(8'hE7);
      idle(3);
      full_byte("R10 idle write taken", 8'h18, 8'hE7);

      // receive-only
      tx_disable = 1'b1;
      ss_n = 1'b0; #1;
      check("R8 oe off when rx-only", sdo_oe, 1'b0);
      ss_n = 1'b1;
      idle(2);
      begin
         ss_n = 1'b0; #20;
         shift_bits(8'h6D, 8, got);
         check("R8 oe stays off", sdo_oe, 1'b0);
         #10; ss_n = 1'b1;
         idle(5);
         check("R8 rx still works", rx_data, 8'h6D);
         pulse_flag_clr();
      end
      tx_disable = 1'b0;

      // select ignored mode
      mode = 4'h5; ss_n = 1'b1;
      write_tx(8'h3A);
      idle(3);
      check("R9 oe with ss_n high", sdo_oe, 1'b1);
      shift_bits(8'hB4, 8, got);
      idle(5);
      check("R9 rx with ss_n high", rx_data, 8'hB4);
      check("R9 miso", got, 8'h3A);
      pulse_flag_clr();
      shift_bits(8'hFF, 3, got);
      idle(2);
      enable = 1'b0; #1;
      check("R6 disable floats sdo", sdo_oe, 1'b0);
      idle(4);
      enable = 1'b1;
      idle(4);
      shift_bits(8'h27, 8, got);
      idle(5);
      check("R6 realigned after disable", rx_data, 8'h27);
      pulse_flag_clr();

      // unsupported mode
      mode = 4'h0; ss_n = 1'b0;
      #1;
      check("R11 oe off in bad mode", sdo_oe, 1'b0);
      shift_bits(8'h99, 8, got);
      idle(5);
      check("R11 no completion", byte_done, 1'b0);
      check("R11 rx unchanged", rx_data, 8'h27);
      ss_n = 1'b1; mode = 4'h4;
      idle(3);

      // wake with system clock stopped
      irq_en = 1'b0;
      idle(1);
      check("R7 no wake idle", wake, 1'b0);
      clk_run = 1'b0;
      #20;
      irq_en = 1'b1;
      ss_n = 1'b0; #20;
      shift_bits(8'hD2, 8, got);
      #10; ss_n = 1'b1; #5;
      check("R7 wake with clk stopped", wake, 1'b1);
      check("R7 flag waits for clk", byte_done, 1'b0);
      clk_run = 1'b1;
      idle(5);
      check("R7 flag after restart", byte_done, 1'b1);
      check("R7 rx after restart", rx_data, 8'hD2);
      check("R7 wake held by flag", wake, 1'b1);
      irq_en = 1'b0; #1;
      check("R7 wake masked", wake, 1'b0);
      pulse_flag_clr();
      irq_en = 1'b1; #1;
      check("R7 wake drops after clear", wake, 1'b0);
      irq_en = 1'b0;

      // random transfers in select mode
      for (int k = 0; k < 16; k++) begin
         m = 8'($urandom);
         t = 8'($urandom);
         write_tx(t);
         idle(3);
         full_byte("R1 R3 random", m, t);
      end
      // edge patterns
      write_tx(8'h00); idle(3); full_byte("R3 all zero", 8'hFF, 8'h00);
      write_tx(8'hFF); idle(3); full_byte("R3 all one", 8'h00, 8'hFF);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule